// File: doc/BRIEF.md
# Sync-Alignment Field Identifier

This block labels each video field as first or second by looking at where the vertical sync active edge falls relative to the horizontal sync active edge. When the two edges land within a tolerance window of each other, the field is the first one. When they do not, it is the second. Some horizontal edges that qualify arrive after the vertical edge. For that reason the block waits through a look-ahead window before it decides, and its answer always comes out after the vertical edge.

Two inputs, both sampled at each accepted vertical edge, decide how the field label is produced. A graphics-timing input forces the label to first field. A source-select input chooses between the label carried on an external field pin and the label derived from the sync edges. Each decision is announced with a one-cycle strobe, and the label holds until the next decision. Both sync inputs must already be active-high when they reach the block.

Top module: `sync_field_id`

## Requirements
- R1: During reset and in the first cycle after it, `fid_o` is 0 and `fid_vld_o` is 0.
- R2: An active edge is a clock at which a sync input is sampled 1 after being sampled 0. A sync input held high gives no further edges. `fid_vld_o` is never high for two cycles in a row.
- R3: When a vertical edge is accepted with `pc_mode_i` = 1, the next cycle shows `fid_vld_o` = 1 and `fid_o` = 0, whatever the sync alignment or the external pin.
- R4: When a vertical edge is accepted with `pc_mode_i` = 0 and `src_sel_i` = 0, the next cycle shows `fid_vld_o` = 1, with `fid_o` equal to the value `ext_fid_i` had in the edge cycle.
- R5: When a vertical edge is accepted with `pc_mode_i` = 0 and `src_sel_i` = 1, `fid_vld_o` stays low for TOL cycles (default 63) and goes high TOL+1 cycles after the edge cycle.
- R6: Derived mode: a horizontal edge in the same cycle as the vertical edge, or 1 to TOL cycles before it, gives `fid_o` = 0 (first field).
- R7: Derived mode: a horizontal edge 1 to TOL cycles after the vertical edge gives `fid_o` = 0.
- R8: Derived mode: when no horizontal edge lies within TOL cycles on either side (for example at a distance of TOL+1), the result is `fid_o` = 1 (second field).
- R9: A vertical edge that arrives while a derived decision is pending is ignored. It produces no strobe and does not alter the pending result.
- R10: `fid_o` changes only in a cycle where `fid_vld_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hs_i | input | 1 | Horizontal sync, active high |
| vs_i | input | 1 | Vertical sync, active high |
| ext_fid_i | input | 1 | External field-ID pin (0 = first field) |
| src_sel_i | input | 1 | 1 = derive from sync alignment, 0 = use external pin |
| pc_mode_i | input | 1 | 1 = graphics timing, label forced to first field |
| fid_o | output | 1 | Field label (0 = first field, 1 = second field) |
| fid_vld_o | output | 1 | One-cycle strobe marking a new decision |

## Verification
The properties assume that every input is synchronous to `clk` and holds steady for a whole cycle. They also assume that a vertical pulse is low for at least one cycle before it rises, so the checker's own edge detection sees the same edges as the block does. The stimulus drives one input value per cycle at the falling clock edge. Each scene is separated by quiet gaps much longer than the tolerance, so edges left over from the previous scene never fall inside a window. Horizontal edges are placed at exact distances around the vertical edge, and a second vertical pulse is sent inside a pending window to exercise the ignore rule.

// File: rtl/fid_pkg.sv
package fid_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_LOOK = 1'b1
  } win_state_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FORCE = 2'd1,
    SRC_PIN = 2'd2,
    SRC_DERIVE = 2'd3
  } fid_src_e;
endpackage

// File: rtl/fid_edge_det.sv
module fid_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] sig_q;
  logic [W-1:0] sig_d;

  always_comb begin
    sig_d = sig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_d;
  end

  for (genvar g = 0; g < W; g++) begin : g_rise
    assign rise_o[g] = sig_i[g] & ~sig_q[g];
  end
endmodule

// File: rtl/fid_hs_age.sv
module fid_hs_age #(
  parameter int TOL = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_rise_i,
  output logic near_o
);
  localparam int AGE_W = $clog2(TOL + 2);
  localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(TOL + 1);
  localparam logic [AGE_W-1:0] AGE_TOL = AGE_W'(TOL);

  logic [AGE_W-1:0] age_q;
  logic [AGE_W-1:0] age_d;
  logic             age_en;

  always_comb begin
    age_en = hs_rise_i | (age_q != AGE_SAT);
    if (hs_rise_i) age_d = AGE_W'(1);
    else           age_d = age_q + AGE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q <= AGE_SAT;
    else if (age_en) age_q <= age_d;
  end

  assign near_o = hs_rise_i | (age_q <= AGE_TOL);
endmodule

// File: rtl/fid_window.sv
module fid_window
  import fid_pkg::*;
#(
  parameter int TOL = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic near_i,
  input  logic hs_rise_i,
  output logic busy_o,
  output logic done_o,
  output logic field2_o
);
  localparam int CNT_W = $clog2(TOL + 1);
  localparam logic [CNT_W-1:0] CNT_TOL = CNT_W'(TOL);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  win_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit_q, hit_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    hit_d = hit_q;
    case (st_q)
      WIN_IDLE: begin
        if (start_i) begin
          st_d  = WIN_LOOK;
          cnt_d = CNT_TOL;
          hit_d = near_i;
        end
      end
      WIN_LOOK: begin
        hit_d = hit_q | hs_rise_i;
        cnt_d = cnt_q - CNT_ONE;
        if (cnt_q == CNT_ONE) st_d = WIN_IDLE;
      end
      default: st_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WIN_IDLE;
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      hit_q <= hit_d;
    end
  end

  assign busy_o   = (st_q == WIN_LOOK);
  assign done_o   = busy_o & (cnt_q == CNT_ONE);
  assign field2_o = ~(hit_q | hs_rise_i);
endmodule

// File: rtl/sync_field_id.sv
module sync_field_id
  import fid_pkg::*;
#(
  parameter int TOL = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_i,
  input  logic vs_i,
  input  logic ext_fid_i,
  input  logic src_sel_i,
  input  logic pc_mode_i,
  output logic fid_o,
  output logic fid_vld_o
);
  logic [1:0] rise;
  logic       hs_rise;
  logic       vs_rise;
  logic       near;
  logic       win_busy;
  logic       win_done;
  logic       win_field2;
  logic       vs_take;
  fid_src_e   src;
  logic       fid_q, fid_d;
  logic       vld_q, vld_d;

  fid_edge_det #(.W(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  ({vs_i, hs_i}),
    .rise_o (rise)
  );

  assign hs_rise = rise[0];
  assign vs_rise = rise[1];

  fid_hs_age #(.TOL(TOL)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_rise_i (hs_rise),
    .near_o    (near)
  );

  assign vs_take = vs_rise & ~win_busy;

  always_comb begin
    if (!vs_take)       src = SRC_NONE;
    else if (pc_mode_i) src = SRC_FORCE;
    else if (!src_sel_i) src = SRC_PIN;
    else                src = SRC_DERIVE;
  end

  fid_window #(.TOL(TOL)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (src == SRC_DERIVE),
    .near_i    (near),
    .hs_rise_i (hs_rise),
    .busy_o    (win_busy),
    .done_o    (win_done),
    .field2_o  (win_field2)
  );

  always_comb begin
    fid_d = fid_q;
    vld_d = 1'b0;
    if (win_done) begin
      fid_d = win_field2;
      vld_d = 1'b1;
    end else begin
      case (src)
        SRC_FORCE: begin
          fid_d = 1'b0;
          vld_d = 1'b1;
        end
        SRC_PIN: begin
          fid_d = ext_fid_i;
          vld_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fid_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      fid_q <= fid_d;
      vld_q <= vld_d;
    end
  end

  assign fid_o     = fid_q;
  assign fid_vld_o = vld_q;
endmodule

// File: rtl/fid_align_chk.sv
module fid_align_chk #(
  parameter int TOL = 63
) (
  input logic clk,
  input logic rst_n,
  input logic vs_i,
  input logic ext_fid_i,
  input logic src_sel_i,
  input logic pc_mode_i,
  input logic win_busy,
  input logic fid_o,
  input logic fid_vld_o
);
  localparam int DW = $clog2(TOL + 2) + 1;
  localparam logic [DW-1:0] D_END = DW'(TOL + 1);
  localparam logic [DW-1:0] D_TOL = DW'(TOL);

  logic          vs_prev;
  logic          vs_edge;
  logic [DW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_prev <= 1'b0;
    else        vs_prev <= vs_i;
  end

  assign vs_edge = vs_i & ~vs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else if (vs_edge && !win_busy && src_sel_i && !pc_mode_i) dcnt <= DW'(1);
    else if (dcnt == D_END) dcnt <= '0;
    else if (dcnt != '0) dcnt <= dcnt + DW'(1);
  end

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    fid_vld_o |=> !fid_vld_o);

  a_r3_pc_forces_first: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_edge && !win_busy && pc_mode_i) |=> (fid_vld_o && !fid_o));

  a_r4_pin_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_edge && !win_busy && !pc_mode_i && !src_sel_i) |=> (fid_vld_o && (fid_o == $past(ext_fid_i))));

  a_r5_decision_late: assert property (@(posedge clk) disable iff (!rst_n)
    (dcnt == D_END) |-> fid_vld_o);

  a_r9_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
    (dcnt != '0 && dcnt <= D_TOL) |-> !fid_vld_o);

  a_r10_hold_label: assert property (@(posedge clk) disable iff (!rst_n)
    !fid_vld_o |-> $stable(fid_o));
endmodule

bind sync_field_id fid_align_chk #(.TOL(TOL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vs_i      (vs_i),
  .ext_fid_i (ext_fid_i),
  .src_sel_i (src_sel_i),
  .pc_mode_i (pc_mode_i),
  .win_busy  (win_busy),
  .fid_o     (fid_o),
  .fid_vld_o (fid_vld_o)
);

// File: tb/sync_field_id_tb.sv
module sync_field_id_tb;
  localparam int TOL = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_i = 1'b0, vs_i = 1'b0, ext_fid_i = 1'b0, src_sel_i = 1'b0, pc_mode_i = 1'b0;
  logic fid_o, fid_vld_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  int cyc = 0;
  int m_hs_prev = 0, m_vs_prev = 0;
  int m_last_hs = -100000;
  int m_busy = 0, m_dec = 0, m_hit = 0;
  int exp_fid = 0, exp_vld = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_field_id #(.TOL(TOL)) u_dut (
    .clk(clk), .rst_n(rst_n), .hs_i(hs_i), .vs_i(vs_i), .ext_fid_i(ext_fid_i),
    .src_sel_i(src_sel_i), .pc_mode_i(pc_mode_i), .fid_o(fid_o), .fid_vld_o(fid_vld_o)
  );

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  // behavioural reference: predicts outputs after the coming rising edge
  task automatic model();
    int hr, vr;
    hr = (hs_i && !m_hs_prev) ? 1 : 0;
    vr = (vs_i && !m_vs_prev) ? 1 : 0;
    exp_vld = 0;
    if (m_busy != 0) begin
      if (hr != 0) m_hit = 1;
      if (cyc == m_dec) begin
        exp_fid = (m_hit != 0) ? 0 : 1;
        exp_vld = 1;
        m_busy = 0;
      end
    end else if (vr != 0) begin
      if (pc_mode_i) begin
        exp_fid = 0; exp_vld = 1;
      end else if (!src_sel_i) begin
        exp_fid = ext_fid_i; exp_vld = 1;
      end else begin
        m_busy = 1;
        m_dec = cyc + TOL;
        m_hit = (hr != 0 || (cyc - m_last_hs) <= TOL) ? 1 : 0;
      end
    end
    if (hr != 0) m_last_hs = cyc;
    m_hs_prev = hs_i;
    m_vs_prev = vs_i;
  endtask

  task automatic step(input logic h, input logic v, input logic e);
    @(negedge clk);
    check(fid_o, exp_fid, "fid_o");
    check(fid_vld_o, exp_vld, "fid_vld_o");
    cyc++;
    hs_i = h; vs_i = v; ext_fid_i = e;
    model();
  endtask

  // one scene: horizontal pulse at hs_t for hs_len cycles, vertical pulses at vs_t and vs_t2
  task automatic scene(input string req, input int hs_t, input int hs_len, input int vs_t,
                       input int vs_t2, input logic ext, input logic sel, input logic pc);
    cur_req = req;
    src_sel_i = sel;
    pc_mode_i = pc;
    for (int i = 0; i < 260; i++) begin
      step((i >= hs_t && i < hs_t + hs_len),
           ((i >= vs_t && i < vs_t + 4) || (i >= vs_t2 && i < vs_t2 + 4)),
           (i == vs_t) ? ext : ~ext);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check(fid_o, 0, "fid_o in reset");
    check(fid_vld_o, 0, "fid_vld_o in reset");
    rst_n = 1'b1;
    step(0, 0, 0);
    step(0, 0, 0);
    // R6: horizontal edge same cycle / before
    scene("R6", 100, 2, 100, -50, 0, 1, 0);
    scene("R6", 99, 2, 100, -50, 0, 1, 0);
    scene("R6", 37, 2, 100, -50, 0, 1, 0);
    // R8: one beyond tolerance before and after, and none at all
    scene("R8", 36, 2, 100, -50, 0, 1, 0);
    scene("R8", 164, 2, 100, -50, 0, 1, 0);
    scene("R8", -50, 2, 100, -50, 0, 1, 0);
    // R7: horizontal edge after vertical edge
    scene("R7", 101, 2, 100, -50, 0, 1, 0);
    scene("R7", 130, 2, 100, -50, 0, 1, 0);
    scene("R7", 163, 2, 100, -50, 0, 1, 0);
    // R5: latency with a second-field result
    scene("R5", -50, 2, 100, -50, 0, 1, 0);
    // R2: horizontal held high long before the vertical edge gives no new edge
    scene("R2", 20, 200, 100, -50, 0, 1, 0);
    // R3: graphics mode forces first field even when misaligned
    scene("R3", -50, 2, 100, -50, 1, 1, 1);
    scene("R3", -50, 2, 100, -50, 1, 0, 1);
    // R4: external pin, both values, pin toggles after the edge
    scene("R4", -50, 2, 100, -50, 1, 0, 0);
    scene("R4", -50, 2, 100, -50, 0, 0, 0);
    // R9: second vertical pulse inside a pending window, with an aligned edge near it
    scene("R9", -50, 2, 100, 130, 0, 1, 0);
    scene("R9", 131, 2, 100, 130, 0, 1, 0);
    // R10: long quiet stretch, label must hold
    scene("R10", -50, 2, -50, -50, 0, 1, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule